// File: doc/BRIEF.md
# Operand Addressing Mode Sequencer

This block turns the per-operand addressing fields of a memory-reference instruction into a resolved operand. The fields are a 2-bit mode code, a 6-bit register field, an indirect flag and a post-index flag, plus a base address taken from the instruction. Scalar instructions and vector instructions use different mode code tables, and the block decodes each through its own path. The result is an operand class with a selector. For memory operands the result also includes an addressing kind and an effective address.

Non-memory operands, and memory operands without indirection, resolve in one cycle. For these the block reads the index value through a 64-entry supplementary register read port. An indirect memory operand starts a single pointer fetch on a request/acknowledge memory port. There are two indirect orders. In pre-indexed indirection the index is added before the fetch. In post-indexed indirection the index is added to the fetched pointer. The one scalar mode code that names no operand class is flagged as an extended-operate case, so that a separate instruction group can be decoded.

Top module: `opnd_addr_seq`

## Requirements
- R1: After reset, `done`, `mem_req` and `busy` are 0.
- R2: A scalar request (`req_vector`=0) with mode 00 completes with `op_class`=0 (register), and mode 11 completes with `op_class`=2 (immediate). In both cases `op_sel` equals `req_field`, `addr_kind`=0, `eff_addr`=0 and `xop`=0.
- R3: A scalar request with mode 10 completes with `xop`=1 and `op_class`=6. It makes no memory access.
- R4: A vector request (`req_vector`=1) with mode 00 gives `op_class`=3 and `op_sel`=0, whatever `req_field` holds. Mode 01 gives `op_class`=4 with `op_sel` equal to the low 3 bits of the field, zero-extended. Mode 10 gives `op_class`=5 with `op_sel`=`req_field`.
- R5: A memory operand is scalar mode 01 or vector mode 11. With field 0 and the indirect flag clear, it completes with `op_class`=1, `addr_kind`=0 (direct) and `eff_addr`=`req_base`. Register 0's contents are not used.
- R6: A memory operand with a nonzero field F and the indirect flag clear gives `addr_kind`=1 (indexed) and `eff_addr`=`req_base` plus register F. `idx_raddr` carries F.
- R7: With the indirect flag clear, the post-index flag has no effect on the result and no fetch is made.
- R8: A memory operand with the indirect flag set, and either the post-index flag clear or a zero index value, fetches once from `req_base` plus the index. It completes with `addr_kind`=2 and `eff_addr` equal to the fetched word.
- R9: A memory operand with both flags set and a nonzero index value fetches once from `req_base`. It completes with `addr_kind`=3 and `eff_addr` equal to the fetched word plus the index.
- R10: `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen. `done` pulses in the cycle after the acknowledge, and `mem_req` is low in that cycle.
- R11: A request presented while `busy` is 1 is dropped. It produces no `done` and does not change the outputs.
- R12: Results without a fetch are reported with `done`=1 in the cycle after `req_valid`. The outputs hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Operand request strobe |
| req_vector | input | 1 | 1 selects the vector mode table |
| req_mode | input | 2 | Operand mode code |
| req_field | input | 6 | Register field |
| req_ind | input | 1 | Indirect flag |
| req_post | input | 1 | Post-index flag |
| req_base | input | 32 | Base address from the instruction |
| idx_raddr | output | 6 | Supplementary register read address |
| idx_rdata | input | 32 | Supplementary register read data (combinational) |
| mem_req | output | 1 | Pointer fetch request |
| mem_addr | output | 32 | Pointer fetch address |
| mem_ack | input | 1 | Fetch acknowledge, data valid |
| mem_rdata | input | 32 | Fetched pointer |
| busy | output | 1 | Pointer fetch in progress |
| done | output | 1 | Result valid pulse |
| xop | output | 1 | Extended-operate flag |
| op_class | output | 3 | Operand class code |
| op_sel | output | 6 | Operand selector |
| addr_kind | output | 2 | 0 direct, 1 indexed, 2 pre-indexed indirect, 3 post-indexed indirect |
| eff_addr | output | 32 | Effective address |

## Verification
Any result that needs no fetch is due one clock after the request edge. The bench therefore samples `done` and the result fields on the first falling edge after it withdraws `req_valid`. An indirect result is due one clock after the edge that sees `mem_ack`. The bench's memory responder raises the acknowledge after a chosen number L of falling edges, so the bench expects `done` exactly L+1 falling edges after the request. It counts the edges it waits and checks that count, together with the number of fetches made. For the dropped-request case, a second request is placed inside the fetch window, and the bench checks that only one `done` appears and that the first result is intact.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  localparam int FIELD_W = 6;
  localparam int VREG_W  = 3;

  typedef enum logic [2:0] {
    CLS_REG  = 3'd0,
    CLS_MEM  = 3'd1,
    CLS_IMM  = 3'd2,
    CLS_SUPV = 3'd3,
    CLS_VREG = 3'd4,
    CLS_SCR  = 3'd5,
    CLS_XOP  = 3'd6
  } opnd_class_e;

  typedef enum logic [1:0] {
    AK_DIRECT   = 2'd0,
    AK_INDEXED  = 2'd1,
    AK_PRE_IND  = 2'd2,
    AK_POST_IND = 2'd3
  } addr_kind_e;

  typedef enum logic {
    PF_IDLE = 1'b0,
    PF_WAIT = 1'b1
  } pf_state_e;
endpackage

// File: rtl/opnd_mode_decode.sv
module opnd_mode_decode
  import opnd_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int VW = VREG_W
) (
  input  logic          is_vector,
  input  logic [1:0]    mode,
  input  logic [FW-1:0] field,
  output opnd_class_e   cls,
  output logic [FW-1:0] sel,
  output logic          is_mem,
  output logic          xop
);
  localparam int PAD_W = FW - VW;

  logic [FW-1:0] sc_sel, vc_sel;
  opnd_class_e   sc_cls, vc_cls;

  // scalar table: 00 reg, 01 mem, 11 imm, 10 extended operate
  always_comb begin
    sc_sel = field;
    unique case (mode)
      2'b00:   sc_cls = CLS_REG;
      2'b01:   sc_cls = CLS_MEM;
      2'b11:   sc_cls = CLS_IMM;
      default: begin sc_cls = CLS_XOP; sc_sel = '0; end
    endcase
  end

  // vector table: 00 supplementary set, 01 vector reg, 10 scratchpad, 11 mem
  always_comb begin
    unique case (mode)
      2'b00:   begin vc_cls = CLS_SUPV; vc_sel = '0; end
      2'b01:   begin vc_cls = CLS_VREG; vc_sel = {{PAD_W{1'b0}}, field[VW-1:0]}; end
      2'b10:   begin vc_cls = CLS_SCR;  vc_sel = field; end
      default: begin vc_cls = CLS_MEM;  vc_sel = field; end
    endcase
  end

  assign cls    = is_vector ? vc_cls : sc_cls;
  assign sel    = is_vector ? vc_sel : sc_sel;
  assign is_mem = (cls == CLS_MEM);
  assign xop    = (cls == CLS_XOP);
endmodule

// File: rtl/opnd_ea_calc.sv
module opnd_ea_calc
  import opnd_pkg::*;
#(
  parameter int AW = 32,
  parameter int FW = FIELD_W
) (
  input  logic [AW-1:0] base,
  input  logic [FW-1:0] field,
  input  logic          ind,
  input  logic          post,
  input  logic [AW-1:0] idx_data,
  output logic [AW-1:0] idx_eff,
  output logic [AW-1:0] direct_ea,
  output logic [AW-1:0] fetch_addr,
  output addr_kind_e    kind
);
  // field zero means no indexing at all
  function automatic logic [AW-1:0] idx_value(input logic [FW-1:0] f,
                                              input logic [AW-1:0] d);
    return (f == '0) ? '0 : d;
  endfunction

  function automatic logic [AW-1:0] ea_add(input logic [AW-1:0] a,
                                           input logic [AW-1:0] b);
    return a + b;
  endfunction

  function automatic addr_kind_e pick_kind(input logic i, input logic p,
                                           input logic [FW-1:0] f,
                                           input logic [AW-1:0] x);
    if (!i)                 return (f == '0) ? AK_DIRECT : AK_INDEXED;
    else if (p && x != '0)  return AK_POST_IND;
    else                    return AK_PRE_IND;
  endfunction

  assign idx_eff    = idx_value(field, idx_data);
  assign direct_ea  = ea_add(base, idx_eff);
  assign kind       = pick_kind(ind, post, field, idx_eff);
  assign fetch_addr = (kind == AK_POST_IND) ? base : direct_ea;
endmodule

// File: rtl/opnd_ptr_fetch.sv
module opnd_ptr_fetch
  import opnd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          start_post,
  input  logic [AW-1:0] start_idx,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic          busy,
  output logic          fin,
  output logic [AW-1:0] fin_addr
);
  pf_state_e     state;
  logic [AW-1:0] addr_q, idx_q;
  logic          post_q;

  function automatic logic [AW-1:0] post_add(input logic [AW-1:0] ptr,
                                             input logic [AW-1:0] x);
    return ptr + x;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PF_IDLE;
      addr_q <= '0;
      idx_q  <= '0;
      post_q <= 1'b0;
    end else begin
      unique case (state)
        PF_IDLE: if (start) begin
          state  <= PF_WAIT;
          addr_q <= start_addr;
          idx_q  <= start_idx;
          post_q <= start_post;
        end
        PF_WAIT: if (mem_ack) state <= PF_IDLE;
        default: state <= PF_IDLE;
      endcase
    end
  end

  assign mem_req  = (state == PF_WAIT);
  assign mem_addr = addr_q;
  assign busy     = mem_req;
  assign fin      = mem_req & mem_ack;
  assign fin_addr = post_q ? post_add(mem_rdata, idx_q) : mem_rdata;
endmodule

// File: rtl/opnd_addr_seq.sv
module opnd_addr_seq
  import opnd_pkg::*;
#(
  parameter int AW = 32,
  parameter int FW = FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_vector,
  input  logic [1:0]    req_mode,
  input  logic [FW-1:0] req_field,
  input  logic          req_ind,
  input  logic          req_post,
  input  logic [AW-1:0] req_base,
  output logic [FW-1:0] idx_raddr,
  input  logic [AW-1:0] idx_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          xop,
  output logic [2:0]    op_class,
  output logic [FW-1:0] op_sel,
  output logic [1:0]    addr_kind,
  output logic [AW-1:0] eff_addr
);
  opnd_class_e   dec_cls;
  logic [FW-1:0] dec_sel;
  logic          dec_mem, dec_xop;
  logic [AW-1:0] idx_eff, direct_ea, fetch_addr, fin_addr;
  addr_kind_e    kind;
  logic          fin;

  // named events for the checker
  logic accept, fetch_start, quick_done;

  assign idx_raddr = req_field;

  opnd_mode_decode #(.FW(FW)) u_dec (
    .is_vector(req_vector), .mode(req_mode), .field(req_field),
    .cls(dec_cls), .sel(dec_sel), .is_mem(dec_mem), .xop(dec_xop)
  );

  opnd_ea_calc #(.AW(AW), .FW(FW)) u_ea (
    .base(req_base), .field(req_field), .ind(req_ind), .post(req_post),
    .idx_data(idx_rdata), .idx_eff(idx_eff), .direct_ea(direct_ea),
    .fetch_addr(fetch_addr), .kind(kind)
  );

  assign accept      = req_valid & ~busy;
  assign fetch_start = accept & dec_mem & req_ind;
  assign quick_done  = accept & ~fetch_start;

  opnd_ptr_fetch #(.AW(AW)) u_pf (
    .clk(clk), .rst_n(rst_n), .start(fetch_start), .start_addr(fetch_addr),
    .start_post(kind == AK_POST_IND), .start_idx(idx_eff),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .busy(busy), .fin(fin), .fin_addr(fin_addr)
  );

  logic [FW-1:0] pend_sel;
  addr_kind_e    pend_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      xop       <= 1'b0;
      op_class  <= CLS_REG;
      op_sel    <= '0;
      addr_kind <= AK_DIRECT;
      eff_addr  <= '0;
      pend_sel  <= '0;
      pend_kind <= AK_DIRECT;
    end else begin
      done <= quick_done | fin;
      if (fetch_start) begin
        pend_sel  <= dec_sel;
        pend_kind <= kind;
      end
      if (quick_done) begin
        xop       <= dec_xop;
        op_class  <= dec_cls;
        op_sel    <= dec_sel;
        addr_kind <= dec_mem ? kind : AK_DIRECT;
        eff_addr  <= dec_mem ? direct_ea : '0;
      end else if (fin) begin
        xop       <= 1'b0;
        op_class  <= CLS_MEM;
        op_sel    <= pend_sel;
        addr_kind <= pend_kind;
        eff_addr  <= fin_addr;
      end
    end
  end
endmodule

// File: rtl/opnd_addr_seq_chk.sv
module opnd_addr_seq_chk #(
  parameter int AW = 32,
  parameter int FW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          req_vector,
  input logic [1:0]    req_mode,
  input logic          req_ind,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic          xop,
  input logic [FW-1:0] op_sel
);
  logic memop;
  assign memop = req_vector ? (req_mode == 2'b11) : (req_mode == 2'b01);

  assert_xop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_vector && req_mode == 2'b10 |=> done && xop && !mem_req);

  assert_vreg_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_vector && req_mode == 2'b01 |=> done && op_sel[FW-1:3] == '0);

  assert_no_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && memop && !req_ind |=> done && !mem_req);

  assert_fetch_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && memop && req_ind |=> mem_req && !done);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  assert_fin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> done && !mem_req);

  assert_no_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> !done);
endmodule

bind opnd_addr_seq opnd_addr_seq_chk #(.AW(AW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .req_vector(req_vector),
  .req_mode(req_mode), .req_ind(req_ind), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .done(done), .xop(xop),
  .op_sel(op_sel)
);

// File: tb/opnd_addr_seq_bench.sv
`timescale 1ns/1ps
module opnd_addr_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_vector = 0, req_ind = 0, req_post = 0;
  logic [1:0]  req_mode = 0;
  logic [5:0]  req_field = 0;
  logic [31:0] req_base = 0;
  logic [5:0]  idx_raddr;
  logic [31:0] idx_rdata;
  logic        mem_req, mem_ack = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic        busy, done, xop;
  logic [2:0]  op_class;
  logic [5:0]  op_sel;
  logic [1:0]  addr_kind;
  logic [31:0] eff_addr;

  int checks = 0, fails = 0, lat = 0, wcnt = 0, fetches = 0, cycles = 0;

  always #2 clk = ~clk;

  opnd_addr_seq u_opnd_addr_seq (.*);

  function automatic logic [31:0] rv(input logic [5:0] a);
    if (a == 0) return 32'h0000_BEEF;
    if (a == 63) return 32'h0;
    return {18'h0, a, 8'h10};
  endfunction
  function automatic logic [31:0] mv(input logic [31:0] a);
    return a ^ 32'hA5A5_0F0F;
  endfunction

  assign idx_rdata = rv(idx_raddr);

  // memory responder: ack after lat falling edges
  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (wcnt == lat) begin
        mem_ack <= 1'b1; mem_rdata <= mv(mem_addr); fetches++; wcnt = 0;
      end else wcnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: act=%0d exp<=20000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one operand request; checks latency, fetch count and every output
  task automatic run_op(input string tag, input logic v, input logic [1:0] m,
                        input logic [5:0] f, input logic i, input logic p,
                        input logic [31:0] b, input int l,
                        input logic [2:0] ecls, input logic [5:0] esel,
                        input logic [1:0] ekind, input logic [31:0] eaddr,
                        input logic exop, input int ewait, input int efetch);
    int n = 0;
    int f0;
    lat = l; f0 = fetches;
    req_vector = v; req_mode = m; req_field = f; req_ind = i; req_post = p;
    req_base = b; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    while (!done && n < 50) begin @(negedge clk); n++; end
    chk({tag, " wait"}, n, ewait);
    chk({tag, " done"}, done, 1);
    chk({tag, " class"}, op_class, ecls);
    chk({tag, " sel"}, op_sel, esel);
    chk({tag, " kind"}, addr_kind, ekind);
    chk({tag, " addr"}, eff_addr, eaddr);
    chk({tag, " xop"}, xop, exop);
    chk({tag, " fetches"}, fetches - f0, efetch);
    @(negedge clk);
    chk({tag, " pulse"}, done, 0);
  endtask

  task automatic t_reset;
    chk("R1 done", done, 0); chk("R1 mem_req", mem_req, 0); chk("R1 busy", busy, 0);
  endtask

  task automatic t_scalar;
    run_op("R2 reg", 0, 2'b00, 6'd17, 0, 0, 32'h100, 0, 3'd0, 6'd17, 0, 0, 0, 0, 0);
    run_op("R2 imm", 0, 2'b11, 6'd42, 1, 1, 32'h100, 0, 3'd2, 6'd42, 0, 0, 0, 0, 0);
    run_op("R3 xop", 0, 2'b10, 6'd9, 1, 0, 32'h100, 0, 3'd6, 6'd0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_vector;
    run_op("R4 supv", 1, 2'b00, 6'd55, 0, 0, 32'h0, 0, 3'd3, 6'd0, 0, 0, 0, 0, 0);
    run_op("R4 vreg", 1, 2'b01, 6'b101110, 0, 0, 32'h0, 0, 3'd4, 6'd6, 0, 0, 0, 0, 0);
    run_op("R4 scr", 1, 2'b10, 6'd37, 0, 0, 32'h0, 0, 3'd5, 6'd37, 0, 0, 0, 0, 0);
  endtask

  task automatic t_mem_direct;
    run_op("R5 direct", 0, 2'b01, 6'd0, 0, 0, 32'h1000_0000, 0, 3'd1, 6'd0, 2'd0,
           32'h1000_0000, 0, 0, 0);
    run_op("R6 indexed", 0, 2'b01, 6'd12, 0, 0, 32'h1000_0000, 0, 3'd1, 6'd12, 2'd1,
           32'h1000_0000 + rv(12), 0, 0, 0);
    run_op("R6 vec indexed", 1, 2'b11, 6'd3, 0, 0, 32'h2000, 0, 3'd1, 6'd3, 2'd1,
           32'h2000 + rv(3), 0, 0, 0);
    run_op("R7 post ignored", 0, 2'b01, 6'd12, 0, 1, 32'h1000_0000, 0, 3'd1, 6'd12,
           2'd1, 32'h1000_0000 + rv(12), 0, 0, 0);
  endtask

  task automatic t_indirect;
    run_op("R8 pre lat0", 0, 2'b01, 6'd4, 1, 0, 32'h3000, 0, 3'd1, 6'd4, 2'd2,
           mv(32'h3000 + rv(4)), 0, 1, 1);
    run_op("R10 pre lat3", 0, 2'b01, 6'd0, 1, 0, 32'h3300, 3, 3'd1, 6'd0, 2'd2,
           mv(32'h3300), 0, 4, 1);
    run_op("R9 post", 0, 2'b01, 6'd20, 1, 1, 32'h4000, 2, 3'd1, 6'd20, 2'd3,
           mv(32'h4000) + rv(20), 0, 3, 1);
    run_op("R9 vec post", 1, 2'b11, 6'd5, 1, 1, 32'h4400, 1, 3'd1, 6'd5, 2'd3,
           mv(32'h4400) + rv(5), 0, 2, 1);
    run_op("R8 post zero idx", 0, 2'b01, 6'd63, 1, 1, 32'h5000, 0, 3'd1, 6'd63, 2'd2,
           mv(32'h5000), 0, 1, 1);
    run_op("R8 post no idx", 0, 2'b01, 6'd0, 1, 1, 32'h5100, 0, 3'd1, 6'd0, 2'd2,
           mv(32'h5100), 0, 1, 1);
  endtask

  task automatic t_busy_drop;
    int n = 0;
    int dones = 0;
    int f0;
    lat = 4; f0 = fetches;
    req_vector = 0; req_mode = 2'b01; req_field = 6'd7; req_ind = 1; req_post = 0;
    req_base = 32'h6000; req_valid = 1;
    @(negedge clk); req_valid = 0;
    @(negedge clk);
    chk("R11 busy", busy, 1);
    req_mode = 2'b11; req_field = 6'd33; req_ind = 0; req_valid = 1;
    @(negedge clk); req_valid = 0;
    n = 2;
    while (n < 10) begin
      if (done) begin
        dones++;
        chk("R11 class", op_class, 3'd1);
        chk("R11 addr", eff_addr, mv(32'h6000 + rv(7)));
        chk("R10 wait", n, 5);
      end
      @(negedge clk); n++;
    end
    chk("R11 single done", dones, 1);
    chk("R11 one fetch", fetches - f0, 1);
    chk("R12 hold class", op_class, 3'd1);
    chk("R12 hold addr", eff_addr, mv(32'h6000 + rv(7)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_scalar;
    t_vector;
    t_mem_direct;
    t_indirect;
    t_busy_drop;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule